// File: doc/BRIEF.md
# Parallel Host Bus Master Sequencer

This block lets synchronous on-chip logic run single byte-wide read and write cycles on an asynchronous peripheral bus. The bus has an active-low chip select and separate active-low read and write strobes. Internal logic raises `req` with the direction, a 3-bit register address and the write byte. The sequencer then produces the whole bus cycle, returns a one-cycle `ack`, and for reads presents the captured byte on `rdata`.

Two address styles are supported and chosen per request. In latched-address mode the register address is placed on the data lines and captured by the peripheral on the falling edge of an address-latch pulse. In dedicated-address mode the address goes out on three separate address lines, and the latch pulse stays low. Every minimum interval on the bus is given in nanoseconds as a parameter. Each one is turned into a clock count by rounding up against `CLK_PERIOD_NS`, so the same RTL meets the bus rules at any clock rate. The tri-state data bus appears as separate output, output-enable and input vectors.

Top module: `hbus_seq`

## Requirements
- R1: In latched-address mode the latch pulse is high for at least 20 ns. The data lines are driven with the address, zero-extended in the upper bits, at least 15 ns before the latch falls. That address is held for at least 8 ns after the latch falls.
- R2: In latched-address mode at least 15 ns pass from the latch falling to the read or write strobe falling, and the latch is never high while a strobe is low.
- R3: In dedicated-address mode the latch stays low. The address lines are valid at least 30 ns before the strobe falls and remain unchanged until after the chip select rises, which is at least 8 ns after the strobe rises.
- R4: The chip select is low whenever a strobe falls, and it rises only after the strobe has risen.
- R5: Each strobe pulse lasts at least 65 ns, and the read and write strobes are never low together.
- R6: For a write, the data output enable is high and the write byte is on the data lines no later than 35 ns after the write strobe falls. Both stay unchanged for at least 8 ns after the strobe rises and throughout the pulse.
- R7: For a read, the data output enable is low for the whole read strobe. The byte on the data input is captured at the last clock of the strobe, at least 65 ns after it fell, and it is presented on `rdata` while `ack` is high.
- R8: After a read strobe rises, the data output enable does not go high again for at least 20 ns.
- R9: At least 150 ns pass from the end of one strobe to the start of the next. A request is accepted only while the sequencer is idle and that recovery time has elapsed. Each accepted request gives exactly one strobe and one `ack` pulse one clock long, and `req` is held until `ack`.
- R10: During and after reset, with no request, chip select, read strobe and write strobe are high, and the latch, the data output enable and `ack` are low.
- R11: A strobe lasts exactly the minimum width rounded up to whole clock periods. This is 80 ns at a 20 ns clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Peripheral register address |
| wdata | input | 8 | Byte to write |
| mode_mux | input | 1 | 1 = latched-address mode, 0 = dedicated-address mode |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| bus_latch | output | 1 | Address latch pulse, active high |
| bus_sel_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_adr | output | 3 | Dedicated address lines |
| bus_dout | output | 8 | Data lines, driven value |
| bus_doe | output | 1 | Data lines output enable |
| bus_din | input | 8 | Data lines, received value |

## Verification
A phase counter loaded with the wrong count shows as a strobe, latch pulse or setup window one clock shorter or longer than expected. It is visible at the first access in the affected mode, at the edge that ends the phase. A recovery counter that fails to reload lets the next request start early, and this shows at the next strobe fall as a gap under 150 ns. A wrongly captured mode or direction shows within one clock of acceptance: a latch pulse in dedicated mode, the output enable held during a read, or the wrong byte written into the peripheral model, which a later read-back then exposes.

// File: rtl/hbus_pkg.sv
`timescale 1ns/1ps
package hbus_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LATCH, S_LGAP, S_SETUP, S_STRB, S_HOLD
  } st_e;

  // whole clock periods covering a nanosecond interval, never below one
  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hbus_dcnt.sv
`timescale 1ns/1ps
// loadable down counter that stops at zero
module hbus_dcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/hbus_drive.sv
`timescale 1ns/1ps
// decodes the bus pins from the sequencer state and the captured request
module hbus_drive import hbus_pkg::*; #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  st_e           st,
  input  logic          mux_q,
  input  logic          we_q,
  input  logic [AW-1:0] adr_q,
  input  logic [DW-1:0] wd_q,
  output logic          latch,
  output logic          sel_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] dout,
  output logic          doe
);
  logic in_strb, data_ph;

  assign in_strb = (st == S_STRB);
  assign data_ph = (st == S_STRB) || (st == S_HOLD);

  assign latch = (st == S_LATCH);
  assign sel_n = (st == S_IDLE);
  assign rd_n  = !(in_strb && !we_q);
  assign wr_n  = !(in_strb && we_q);

  always_comb begin
    if (mux_q && !(we_q && data_ph)) dout = DW'(adr_q);
    else                             dout = wd_q;
  end

  always_comb begin
    case (st)
      S_LATCH, S_LGAP:          doe = 1'b1;
      S_SETUP, S_STRB, S_HOLD:  doe = we_q;
      default:                  doe = 1'b0;
    endcase
  end
endmodule

// File: rtl/hbus_seq.sv
`timescale 1ns/1ps
module hbus_seq import hbus_pkg::*; #(
  parameter int AW             = 3,
  parameter int DW             = 8,
  parameter int CLK_PERIOD_NS  = 20,
  parameter int T_LATCH_HI_NS  = 20,
  parameter int T_MUX_ASU_NS   = 15,
  parameter int T_MUX_AH_NS    = 8,
  parameter int T_L2S_NS       = 15,
  parameter int T_STRB_W_NS    = 65,
  parameter int T_SEP_ASU_NS   = 30,
  parameter int T_AH_NS        = 8,
  parameter int T_DH_NS        = 8,
  parameter int T_RDV_NS       = 65,
  parameter int T_REL_NS       = 20,
  parameter int T_RECOV_NS     = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          mode_mux,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          bus_latch,
  output logic          bus_sel_n,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic [AW-1:0] bus_adr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din
);
  localparam int P         = CLK_PERIOD_NS;
  localparam int LATCH_CYC = imax(ns2cyc(T_LATCH_HI_NS, P), ns2cyc(T_MUX_ASU_NS, P));
  localparam int LGAP_CYC  = imax(ns2cyc(T_MUX_AH_NS, P), ns2cyc(T_L2S_NS, P));
  localparam int SETUP_CYC = ns2cyc(T_SEP_ASU_NS, P);
  localparam int WR_CYC    = ns2cyc(T_STRB_W_NS, P);
  localparam int RD_CYC    = imax(WR_CYC, ns2cyc(T_RDV_NS, P));
  localparam int HOLD_CYC  = imax(ns2cyc(T_AH_NS, P), ns2cyc(T_DH_NS, P));
  localparam int RECOV_CYC = imax(ns2cyc(T_RECOV_NS, P), ns2cyc(T_REL_NS, P));
  localparam int PH_MAX    = imax(imax(LATCH_CYC, LGAP_CYC),
                                  imax(imax(SETUP_CYC, RD_CYC), HOLD_CYC));
  localparam int PH_W      = $clog2(PH_MAX + 1);
  localparam int RC_W      = $clog2(RECOV_CYC + 1);

  st_e            st, st_nx;
  logic           mux_q, we_q;
  logic [AW-1:0]  adr_q;
  logic [DW-1:0]  wd_q, rd_q;
  logic           ph_ld, ph_zero;
  logic [PH_W-1:0] ph_val;
  logic           rc_zero;

  // named internal events
  logic acc_fire;   // request accepted this cycle
  logic strb_end;   // strobe rises after this edge
  logic rd_smp;     // read byte captured at this edge

  always_comb begin
    st_nx    = st;
    ph_ld    = 1'b0;
    ph_val   = '0;
    acc_fire = 1'b0;
    strb_end = 1'b0;
    rd_smp   = 1'b0;
    case (st)
      S_IDLE: if (req && rc_zero) begin
        acc_fire = 1'b1;
        ph_ld    = 1'b1;
        if (mode_mux) begin st_nx = S_LATCH; ph_val = PH_W'(LATCH_CYC - 1); end
        else          begin st_nx = S_SETUP; ph_val = PH_W'(SETUP_CYC - 1); end
      end
      S_LATCH: if (ph_zero) begin
        st_nx = S_LGAP; ph_ld = 1'b1; ph_val = PH_W'(LGAP_CYC - 1);
      end
      S_LGAP, S_SETUP: if (ph_zero) begin
        st_nx  = S_STRB; ph_ld = 1'b1;
        ph_val = we_q ? PH_W'(WR_CYC - 1) : PH_W'(RD_CYC - 1);
      end
      S_STRB: if (ph_zero) begin
        st_nx    = S_HOLD; ph_ld = 1'b1; ph_val = PH_W'(HOLD_CYC - 1);
        strb_end = 1'b1;
        rd_smp   = !we_q;
      end
      S_HOLD: if (ph_zero) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      mux_q <= 1'b0;
      we_q  <= 1'b0;
      adr_q <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
    end else begin
      st <= st_nx;
      if (acc_fire) begin
        mux_q <= mode_mux;
        we_q  <= we;
        adr_q <= addr;
        wd_q  <= wdata;
      end
      if (rd_smp) rd_q <= bus_din;
    end
  end

  hbus_dcnt #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_ld), .val(ph_val), .zero(ph_zero)
  );

  hbus_dcnt #(.W(RC_W)) u_recov (
    .clk(clk), .rst_n(rst_n), .load(strb_end),
    .val(RC_W'(RECOV_CYC - 1)), .zero(rc_zero)
  );

  hbus_drive #(.AW(AW), .DW(DW)) u_drive (
    .st(st), .mux_q(mux_q), .we_q(we_q), .adr_q(adr_q), .wd_q(wd_q),
    .latch(bus_latch), .sel_n(bus_sel_n), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
    .dout(bus_dout), .doe(bus_doe)
  );

  assign bus_adr = adr_q;
  assign rdata   = rd_q;
  assign ack     = (st == S_HOLD) && ph_zero;
endmodule

// File: rtl/hbus_seq_chk.sv
`timescale 1ns/1ps
module hbus_seq_chk import hbus_pkg::*; #(
  parameter int DW            = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_STRB_W_NS   = 65,
  parameter int T_RECOV_NS    = 150
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_latch,
  input logic          bus_sel_n,
  input logic          bus_rd_n,
  input logic          bus_wr_n,
  input logic          bus_doe,
  input logic [DW-1:0] bus_dout,
  input logic          ack
);
  localparam logic [15:0] W_MIN = 16'(ns2cyc(T_STRB_W_NS, CLK_PERIOD_NS));
  localparam logic [15:0] R_MIN = 16'(ns2cyc(T_RECOV_NS, CLK_PERIOD_NS));

  logic        strb, strb_d;
  logic [15:0] lo_cnt, gap_cnt;

  assign strb = !bus_rd_n || !bus_wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_d  <= 1'b0;
      lo_cnt  <= '0;
      gap_cnt <= 16'hFFFF;
    end else begin
      strb_d <= strb;
      if (!strb)                 lo_cnt <= '0;
      else if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 16'd1;
      if (!strb && strb_d)        gap_cnt <= 16'd1;
      else if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 16'd1;
    end
  end

  p_sel_cover_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> !bus_sel_n);
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_n || bus_wr_n);
  p_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb && strb_d) |-> (lo_cnt >= W_MIN));
  p_latch_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_latch |-> (bus_rd_n && bus_wr_n));
  p_wdata_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && $past(!bus_wr_n)) |-> ($stable(bus_dout) && bus_doe));
  p_read_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_doe);
  p_recovery_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && !strb_d) |-> (gap_cnt >= R_MIN));
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
endmodule

bind hbus_seq hbus_seq_chk #(
  .DW(DW), .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_STRB_W_NS(T_STRB_W_NS), .T_RECOV_NS(T_RECOV_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_latch(bus_latch), .bus_sel_n(bus_sel_n),
  .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_doe(bus_doe),
  .bus_dout(bus_dout), .ack(ack)
);

// File: tb/hbus_seq_tb_top.sv
`timescale 1ns/1ps
module hbus_seq_tb_top;
  localparam int PER   = 20;
  localparam int W_EXP = ((65 + PER - 1) / PER) * PER;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0, mode_mux = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       ack, bus_latch, bus_sel_n, bus_rd_n, bus_wr_n, bus_doe;
  logic [7:0] rdata, bus_dout;
  logic [7:0] bus_din = 8'h00;
  logic [2:0] bus_adr;

  always #10 clk = ~clk;

  hbus_seq #(.CLK_PERIOD_NS(PER)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .mode_mux(mode_mux), .ack(ack), .rdata(rdata), .bus_latch(bus_latch),
    .bus_sel_n(bus_sel_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_adr(bus_adr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
  );

  int nchk = 0, nerr = 0, nstrb = 0;
  bit started = 0, done = 0;
  bit cur_mux, cur_we;
  logic [2:0] exp_addr, lat_a, p_a;
  logic [7:0] exp_wd;
  logic [7:0] pmem [8];
  logic [7:0] exp_mem [8];
  realtime t_lr, t_lf, t_dchg, t_achg, t_sf, t_sr;
  bit lf_pend = 0, wd_pend = 0, rd_done = 0, have_sr = 0, in_acc = 0, rose = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // ---------------- bus-side monitors and peripheral model ----------------
  always @(posedge bus_latch) begin
    t_lr = $realtime;
    if (started) chk(cur_mux, "R3 latch pulse in dedicated mode", 1, 0);
  end

  always @(negedge bus_latch) if (started) begin
    realtime t;
    t = $realtime; t_lf = t; lf_pend = 1;
    chk(t - t_lr >= 20, "R1 latch width ns", int'(t - t_lr), 20);
    chk(t - t_dchg >= 15, "R1 address setup ns", int'(t - t_dchg), 15);
    #1;
    chk(bus_doe && bus_dout == {5'b0, exp_addr}, "R1 address on data lines",
        int'(bus_dout), int'({5'b0, exp_addr}));
    lat_a = bus_dout[2:0];
  end

  always @(bus_dout or bus_doe) begin
    realtime t;
    t = $realtime;
    if (lf_pend) begin chk(t - t_lf >= 8, "R1 address hold ns", int'(t - t_lf), 8); lf_pend = 0; end
    if (wd_pend) begin chk(t - t_sr >= 8, "R6 write data hold ns", int'(t - t_sr), 8); wd_pend = 0; end
    t_dchg = t;
  end

  always @(bus_adr) t_achg = $realtime;

  always @(negedge bus_rd_n or negedge bus_wr_n) if (started) begin
    realtime t;
    t = $realtime; t_sf = t; in_acc = 1; rose = 0; nstrb++;
    if (have_sr) chk(t - t_sr >= 150, "R9 recovery ns", int'(t - t_sr), 150);
    if (cur_mux) chk(t - t_lf >= 15, "R2 latch to strobe ns", int'(t - t_lf), 15);
    else chk(t - t_achg >= 30, "R3 address setup ns", int'(t - t_achg), 30);
    #1;
    chk(!bus_sel_n, "R4 select low at strobe fall", int'(bus_sel_n), 0);
    chk(bus_rd_n || bus_wr_n, "R5 both strobes low", 0, 1);
    if (!cur_mux) chk(bus_adr == exp_addr, "R3 address lines", int'(bus_adr), int'(exp_addr));
    p_a = cur_mux ? lat_a : bus_adr;
    if (!bus_rd_n) begin
      chk(!bus_doe, "R7 output enable off during read", int'(bus_doe), 0);
      bus_din = 8'hEE;
      #64;
      bus_din = pmem[p_a];
    end
  end

  always @(posedge bus_rd_n or posedge bus_wr_n) if (in_acc && !rose) begin
    realtime t;
    t = $realtime; t_sr = t; have_sr = 1; rose = 1;
    chk(t - t_sf >= 65, "R5 strobe width ns", int'(t - t_sf), 65);
    chk(int'(t - t_sf) == W_EXP, "R11 strobe width exact ns", int'(t - t_sf), W_EXP);
    if (cur_we) begin
      wd_pend = 1;
      chk(t_dchg - t_sf <= 35, "R6 data valid after fall ns", int'(t_dchg - t_sf), 35);
      chk(bus_doe && bus_dout == exp_wd, "R6 write byte", int'(bus_dout), int'(exp_wd));
      pmem[p_a] = bus_dout;
    end else begin
      rd_done = 1;
      #20 bus_din = 8'h00;
    end
  end

  always @(posedge bus_doe) if (rd_done) begin
    chk($realtime - t_sr >= 20, "R8 enable after read ns", int'($realtime - t_sr), 20);
    rd_done = 0;
  end

  always @(posedge bus_sel_n) if (in_acc) begin
    chk(rose && $realtime >= t_sr, "R4 select rises after strobe", int'(rose), 1);
    #1;
    if (!cur_mux) chk(bus_adr == exp_addr && t_achg < t_sf, "R3 address held", int'(bus_adr), int'(exp_addr));
    in_acc = 0;
  end

  // ---------------- request side ----------------
  task automatic run_acc(input bit m, input bit w, input logic [2:0] a, input logic [7:0] d);
    int n0, wc;
    n0 = nstrb; wc = 0;
    cur_mux = m; cur_we = w; exp_addr = a; exp_wd = d;
    @(negedge clk);
    mode_mux = m; we = w; addr = a; wdata = d; req = 1'b1;
    do begin @(negedge clk); wc++; end while (!ack && wc < 100);
    chk(ack, "R9 ack returned", int'(ack), 1);
    if (!w) chk(rdata == exp_mem[a], "R7 read byte", int'(rdata), int'(exp_mem[a]));
    else exp_mem[a] = d;
    req = 1'b0;
    @(negedge clk);
    chk(!ack, "R9 ack one cycle", int'(ack), 0);
    chk(nstrb - n0 == 1, "R9 one strobe per request", nstrb - n0, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(bus_sel_n && bus_rd_n && bus_wr_n, "R10 strobes idle in reset", 0, 1);
    chk(!bus_latch && !bus_doe && !ack, "R10 latch, enable, ack low", 1, 0);
    rst_n = 1'b1; started = 1;
    repeat (3) @(negedge clk);
    chk(bus_sel_n && bus_rd_n && bus_wr_n && !bus_doe && !ack, "R10 idle after reset", 0, 1);
  endtask

  task automatic t_latched;
    run_acc(1'b1, 1'b1, 3'd5, 8'hA7);
    run_acc(1'b1, 1'b0, 3'd5, 8'h00);
  endtask

  task automatic t_dedicated;
    run_acc(1'b0, 1'b1, 3'd2, 8'h5C);
    run_acc(1'b0, 1'b0, 3'd2, 8'h00);
    run_acc(1'b0, 1'b0, 3'd5, 8'h00);
  endtask

  task automatic t_mixed;
    run_acc(1'b1, 1'b1, 3'd7, 8'hE1);
    run_acc(1'b0, 1'b1, 3'd7, 8'h1E);
    run_acc(1'b1, 1'b0, 3'd7, 8'h00);
  endtask

  task automatic t_untouched;
    run_acc(1'b0, 1'b0, 3'd0, 8'h00);
    run_acc(1'b1, 1'b0, 3'd3, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      pmem[i] = 8'h30 + 8'(i);
      exp_mem[i] = 8'h30 + 8'(i);
    end
    t_dchg = 0; t_achg = 0; t_lr = 0; t_lf = 0; t_sf = 0; t_sr = 0;
    t_reset;
    t_latched;
    t_dedicated;
    t_mixed;
    t_untouched;
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule